// File: doc/BRIEF.md
# Three-Wire Serial Shift Unit

This block is a small serial port that swaps one byte with a peer over a three-line link: a data input, a data output and a serial clock. It can act as either the clock-driving side or the clock-following side. The link behaves like SPI in modes 0 and 1. There is no chip-select line, so any select behaviour is left to the host. There is also no clock generator. On the driving side, the host makes each clock edge itself, either with a toggle strobe or by writing a clock level directly.

The serial clock and data input pass through a two-flop synchronizer and an edge detector that run on the system clock. Each detected edge does two things. It steps a free-running 4-bit edge counter. Depending on the selected mode, it also samples the data input or shifts the 8-bit register. The data register shifts most-significant bit first.

A byte takes sixteen edges. After the sixteenth edge the counter wraps from 15 to 0 and sets a sticky completion flag. The host reads the flag to learn that the transfer has finished. The host can also preload the counter and clear the flag.

Register map (2-bit address):

| Address | Register | Write | Read |
|---|---|---|---|
| 0 | Data | Loads the shift register. | The shift register. |
| 1 | Control | bit0 mode; bit1 drive clock; bit2 toggle; bit3 load level; bit4 level | bit0 mode; bit1 drive clock; bit4 current clock output; toggle reads 0 |
| 2 | Status | bit4 = 1 clears the flag; bit5 = 1 loads bits[3:0] into the counter | bits[3:0] counter; bit4 flag |
| 3 | None | No effect. | 0 |

Top module: `wire3_shift_unit`

## Requirements
- R1: After reset, the data, control and status registers all read 0. The clock output, the clock output enable and the data output are all 0.
- R2: A write to address 0 loads the shift register, and address 0 reads it back. The data output always shows bit 7 of the shift register, and a write changes it on the next system clock.
- R3: In mode 0 (control bit0 = 0), the data input is sampled on rising edges of the serial clock and the register shifts left on falling edges. When the clock idles low, eight clock cycles swap the bytes of two linked units, most-significant bit first.
- R4: In mode 1 (control bit0 = 1), the data input is sampled on falling edges and the register shifts on rising edges. When the clock idles high, eight clock cycles swap the bytes of two linked units.
- R5: Every rising and every falling serial clock edge adds one to the 4-bit counter, which reads at status bits[3:0].
- R6: The flag (status bit4) sets on the edge that wraps the counter from 15 to 0. After fifteen edges from a count of 0 the flag is still clear.
- R7: Once set, the flag stays set until a status write with bit4 = 1 clears it. Clearing the flag leaves the counter value unchanged.
- R8: A status write with bit5 = 1 loads bits[3:0] into the counter. A load takes priority over an edge arriving in the same cycle.
- R9: If an overflow and a flag-clear write land in the same cycle, the flag ends up set.
- R10: A control write with bit2 = 1 inverts the clock output. A control write with bit3 = 1 sets the clock output to bit4. Bit2 always reads back as 0.
- R11: With control bit1 = 1, the unit takes its serial clock from its own clock output and raises the clock output enable. With bit1 = 0, it takes its clock from the clock input and ignores its own clock output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| sck_i | input | 1 | Serial clock input (clock-following side) |
| sck_o | output | 1 | Serial clock output (clock-driving side) |
| sck_oe | output | 1 | Serial clock output enable |
| di_i | input | 1 | Serial data input |
| do_o | output | 1 | Serial data output |
| xfer_done_o | output | 1 | Completion flag |

## Verification
The counter overflow and a host write that clears the flag can arrive in the same system cycle. The bench first preloads the counter to 15. It then issues a clock toggle, and exactly three system cycles later, once the edge has passed through the two synchronizer stages and the edge register, it issues the clear write. The flag must read as set and the counter as 0. A second clear with no edge pending must then leave the flag clear.

// File: rtl/wire3_pkg.sv
// Package wire3_pkg
// Shared register addresses and control/status bit positions of the
// three-wire shift unit. Assumes an 8-bit host data path.
package wire3_pkg;

    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_CTRL = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_NONE = 2'd3
    } w3_addr_e;

    // Control register bit positions
    localparam int CTRL_MODE   = 0;
    localparam int CTRL_MASTER = 1;
    localparam int CTRL_TOGGLE = 2;
    localparam int CTRL_LVLLD  = 3;
    localparam int CTRL_LEVEL  = 4;

    // Status register bit positions
    localparam int STAT_FLAG   = 4;
    localparam int STAT_LOAD   = 5;

endpackage

// File: rtl/w3_sync_edge.sv
// Module w3_sync_edge
// Brings the serial clock and data input into the system clock domain
// through a STAGES-deep flop chain, then flags rising and falling edges
// of the synchronized clock as single-cycle pulses. The data output is
// delayed by the same number of stages, so it stays aligned with the clock.
// Assumes STAGES >= 2 and a serial clock much slower than clk.
module w3_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_raw,
    input  logic di_raw,
    output logic sck_rise,
    output logic sck_fall,
    output logic di_sync
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sck_chain;
    logic [STAGES-1:0] di_chain;
    logic              sck_last;

    // Shift the raw inputs through the synchronizer chains
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_chain <= '0;
            di_chain  <= '0;
        end else begin
            sck_chain <= {sck_chain[STAGES-2:0], sck_raw};
            di_chain  <= {di_chain[STAGES-2:0], di_raw};
        end
    end

    // Remember the previous synchronized clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_last <= 1'b0;
        else        sck_last <= sck_chain[TOP];
    end

    // Decode edges from the current and previous synchronized levels
    always_comb begin
        sck_rise = sck_chain[TOP] & ~sck_last;
        sck_fall = ~sck_chain[TOP] & sck_last;
        di_sync  = di_chain[TOP];
    end

endmodule

// File: rtl/w3_shift_reg.sv
// Module w3_shift_reg
// Shift register of WIDTH bits with a one-bit sample latch. A sample
// enable captures the input bit. A shift enable moves the register left
// and inserts the captured bit. A host load takes priority over a shift.
// Assumes the sample and shift enables never arrive in the same cycle.
module w3_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             sample_en,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] q,
    output logic             dout
);
    logic samp_bit;

    // Capture the incoming serial bit on the sample edge
    always_ff @(posedge clk) begin
        if (!rst_n)         samp_bit <= 1'b0;
        else if (sample_en) samp_bit <= din;
    end

    // Load from the host, or shift left and insert the captured bit
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (load_en)  q <= load_val;
        else if (shift_en) q <= {q[WIDTH-2:0], samp_bit};
    end

    // Serial output is the current most-significant bit
    always_comb dout = q[WIDTH-1];

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> q == $past(load_val));

    // R3
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load_en) |=> q == {$past(q[WIDTH-2:0]), $past(samp_bit)});

endmodule

// File: rtl/w3_edge_count.sv
// Module w3_edge_count
// Free-running CNT_W-bit edge counter with a sticky overflow flag. A host
// load takes priority over a step. The flag sets when a step wraps the
// count from all-ones to zero, and a host clear removes it. If a set and
// a clear arrive in the same cycle, the set wins.
module w3_edge_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic wrap;

    // Detect a step that wraps the count from all-ones to zero
    always_comb wrap = step && !load && (cnt == CNT_MAX);

    // Load the counter or advance it by one per edge
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (step) cnt <= cnt + 1'b1;
    end

    // Sticky flag: a wrap sets it and takes priority over a host clear
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (wrap) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R8
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cnt == CNT_MAX) |=> flag);

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/wire3_shift_unit.sv
// Module wire3_shift_unit
// Three-wire serial shift unit that can drive or follow the serial clock.
// The host accesses data, control and status registers. On the clock-driving
// side, the serial clock comes only from host writes (toggle strobe or
// level load). Edges of the serial clock are synchronized, then used to
// sample, shift and count. Assumes DATA_W >= 8 and CNT_W <= 4.
module wire3_shift_unit
    import wire3_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              di_i,
    output logic              do_o,
    output logic              xfer_done_o
);
    logic              mode_q, master_q, sck_q;
    logic              wr_data, wr_ctrl, wr_stat;
    logic              tog_wr, lvl_wr;
    logic              sck_src;
    logic              rise, fall, di_s;
    logic              sample_en, shift_en, step;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              flag;

    // Decode host writes per register
    always_comb begin
        wr_data = host_we && (w3_addr_e'(host_addr) == ADDR_DATA);
        wr_ctrl = host_we && (w3_addr_e'(host_addr) == ADDR_CTRL);
        wr_stat = host_we && (w3_addr_e'(host_addr) == ADDR_STAT);
        tog_wr  = wr_ctrl && host_wdata[CTRL_TOGGLE];
        lvl_wr  = wr_ctrl && host_wdata[CTRL_LVLLD] && !host_wdata[CTRL_TOGGLE];
    end

    // Hold the mode and clock-drive control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            master_q <= 1'b0;
        end else if (wr_ctrl) begin
            mode_q   <= host_wdata[CTRL_MODE];
            master_q <= host_wdata[CTRL_MASTER];
        end
    end

    // Drive the serial clock output from toggle or level-load writes
    always_ff @(posedge clk) begin
        if (!rst_n)      sck_q <= 1'b0;
        else if (tog_wr) sck_q <= ~sck_q;
        else if (lvl_wr) sck_q <= host_wdata[CTRL_LEVEL];
    end

    // Pick the clock that feeds the engine: own output or external input
    always_comb sck_src = master_q ? sck_q : sck_i;

    w3_sync_edge #(
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_raw  (sck_src),
        .di_raw   (di_i),
        .sck_rise (rise),
        .sck_fall (fall),
        .di_sync  (di_s)
    );

    // Map clock edges to sample, shift and count enables per mode
    always_comb begin
        sample_en = mode_q ? fall : rise;
        shift_en  = mode_q ? rise : fall;
        step      = rise | fall;
    end

    w3_shift_reg #(
        .WIDTH     (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (wr_data),
        .load_val  (host_wdata),
        .sample_en (sample_en),
        .shift_en  (shift_en),
        .din       (di_s),
        .q         (shreg),
        .dout      (do_o)
    );

    w3_edge_count #(
        .CNT_W    (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (wr_stat && host_wdata[STAT_LOAD]),
        .load_val (host_wdata[CNT_W-1:0]),
        .clr      (wr_stat && host_wdata[STAT_FLAG]),
        .cnt      (cnt),
        .flag     (flag)
    );

    // Read multiplexer for the host
    always_comb begin
        host_rdata = '0;
        unique case (w3_addr_e'(host_addr))
            ADDR_DATA: host_rdata = shreg;
            ADDR_CTRL: begin
                host_rdata[CTRL_MODE]   = mode_q;
                host_rdata[CTRL_MASTER] = master_q;
                host_rdata[CTRL_LEVEL]  = sck_q;
            end
            ADDR_STAT: begin
                host_rdata[CNT_W-1:0]   = cnt;
                host_rdata[STAT_FLAG]   = flag;
            end
            default: host_rdata = '0;
        endcase
    end

    // Drive the pad-side outputs
    always_comb begin
        sck_o       = sck_q;
        sck_oe      = master_q;
        xfer_done_o = flag;
    end

    // R10
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tog_wr |=> sck_q != $past(sck_q));

    // R3
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_en && shift_en));

endmodule

// File: tb/wire3_shift_unit_bench.sv
// Directed bench: a clock-driving unit and a clock-following unit wired
// back to back, one task per scenario.
module wire3_shift_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_we = 1'b0, s_we = 1'b0;
    logic [1:0] m_addr = 2'd0, s_addr = 2'd0;
    logic [7:0] m_wdata = 8'd0, s_wdata = 8'd0;
    logic [7:0] m_rdata, s_rdata;
    logic       m_sck, m_oe, m_do, m_done;
    logic       s_sck, s_oe, s_do, s_done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    wire3_shift_unit u_wire3_shift_unit (
        .clk (clk), .rst_n (rst_n), .host_we (m_we), .host_addr (m_addr),
        .host_wdata (m_wdata), .host_rdata (m_rdata), .sck_i (1'b0),
        .sck_o (m_sck), .sck_oe (m_oe), .di_i (s_do), .do_o (m_do),
        .xfer_done_o (m_done)
    );

    wire3_shift_unit u_peer (
        .clk (clk), .rst_n (rst_n), .host_we (s_we), .host_addr (s_addr),
        .host_wdata (s_wdata), .host_rdata (s_rdata), .sck_i (m_sck),
        .sck_o (s_sck), .sck_oe (s_oe), .di_i (m_do), .do_o (s_do),
        .xfer_done_o (s_done)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Called at a negedge; the write is taken at the following posedge
    task automatic m_wr(input logic [1:0] a, input logic [7:0] d);
        m_we = 1'b1; m_addr = a; m_wdata = d;
        @(negedge clk);
        m_we = 1'b0;
    endtask

    task automatic s_wr(input logic [1:0] a, input logic [7:0] d);
        s_we = 1'b1; s_addr = a; s_wdata = d;
        @(negedge clk);
        s_we = 1'b0;
    endtask

    task automatic m_rd(input logic [1:0] a, output logic [7:0] d);
        m_addr = a; #1 d = m_rdata;
    endtask

    task automatic s_rd(input logic [1:0] a, output logic [7:0] d);
        s_addr = a; #1 d = s_rdata;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        m_rd(2'd0, v); check(v, 8'h00, "R1 data after reset");
        m_rd(2'd1, v); check(v, 8'h00, "R1 ctrl after reset");
        m_rd(2'd2, v); check(v, 8'h00, "R1 status after reset");
        check({5'd0, m_sck, m_oe, m_do}, 8'h00, "R1 sck_o/sck_oe/do_o after reset");
    endtask

    task automatic t_data_write();
        logic [7:0] v;
        m_wr(2'd0, 8'hA5);
        check({7'd0, m_do}, 8'h01, "R2 do_o follows msb after write");
        m_rd(2'd0, v); check(v, 8'hA5, "R2 data readback");
        m_wr(2'd0, 8'h5A);
        check({7'd0, m_do}, 8'h00, "R2 do_o after second write");
    endtask

    task automatic t_clock_drive();
        logic [7:0] v;
        m_wr(2'd1, 8'h02);
        check({7'd0, m_oe}, 8'h01, "R11 sck_oe when driving clock");
        m_wr(2'd1, 8'h06);
        check({7'd0, m_sck}, 8'h01, "R10 toggle raises sck_o");
        m_rd(2'd1, v); check(v, 8'h12, "R10 toggle bit reads 0");
        m_wr(2'd1, 8'h06);
        check({7'd0, m_sck}, 8'h00, "R10 toggle lowers sck_o");
        m_wr(2'd1, 8'h1A);
        check({7'd0, m_sck}, 8'h01, "R10 level load high");
        m_wr(2'd1, 8'h0A);
        check({7'd0, m_sck}, 8'h00, "R10 level load low");
        settle();
    endtask

    task automatic t_counter();
        logic [7:0] v;
        m_wr(2'd2, 8'h35);
        m_rd(2'd2, v); check(v, 8'h05, "R8 counter preload");
        m_wr(2'd1, 8'h06);
        settle();
        m_rd(2'd2, v); check(v, 8'h06, "R5 counter steps on rising edge");
        m_wr(2'd1, 8'h06);
        settle();
        m_rd(2'd2, v); check(v, 8'h07, "R5 counter steps on falling edge");
    endtask

    // Prepare both units, then run sixteen edges and check the exchange
    task automatic exchange(input logic [7:0] mb, input logic [7:0] sb,
                            input logic [7:0] tog, input string req);
        logic [7:0] v;
        m_wr(2'd0, mb); s_wr(2'd0, sb);
        m_wr(2'd2, 8'h30); s_wr(2'd2, 8'h30);
        for (int e = 0; e < 16; e++) begin
            m_wr(2'd1, tog);
            settle();
            if (e == 14) begin
                m_rd(2'd2, v); check(v, 8'h0F, {req, " R6 no flag after 15 edges"});
            end
        end
        m_rd(2'd0, v); check(v, sb, {req, " master holds peer byte"});
        s_rd(2'd0, v); check(v, mb, {req, " peer holds master byte"});
        m_rd(2'd2, v); check(v, 8'h10, {req, " R6 flag set and counter wrapped"});
        s_rd(2'd2, v); check(v, 8'h10, {req, " R6 peer flag set"});
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        settle();
        m_wr(2'd2, 8'h29);
        m_rd(2'd2, v); check(v, 8'h19, "R7 flag sticky across counter load");
        m_wr(2'd2, 8'h10);
        m_rd(2'd2, v); check(v, 8'h09, "R7 clear keeps counter value");
    endtask

    task automatic t_mode1();
        m_wr(2'd1, 8'h1B); s_wr(2'd1, 8'h01);
        settle();
        exchange(8'h96, 8'h3C, 8'h07, "R4 mode1");
        m_wr(2'd1, 8'h0A); s_wr(2'd1, 8'h00);
        settle();
    endtask

    task automatic t_conflict();
        logic [7:0] v;
        m_wr(2'd2, 8'h3F);
        m_wr(2'd1, 8'h06);
        repeat (2) @(negedge clk);
        m_wr(2'd2, 8'h10);
        m_rd(2'd2, v); check(v, 8'h10, "R9 overflow beats same-cycle clear");
        m_wr(2'd2, 8'h10);
        m_rd(2'd2, v); check(v, 8'h00, "R9 lone clear removes flag");
        m_wr(2'd1, 8'h06);
        settle();
    endtask

    task automatic t_follower_ignores_own();
        logic [7:0] v;
        s_wr(2'd2, 8'h30);
        s_wr(2'd1, 8'h04);
        settle();
        check({7'd0, s_sck}, 8'h01, "R11 follower sck_o toggled");
        check({7'd0, s_oe}, 8'h00, "R11 follower sck_oe low");
        s_rd(2'd2, v); check(v, 8'h00, "R11 follower ignores its own clock");
        s_wr(2'd1, 8'h04);
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_write();
        t_clock_drive();
        t_counter();
        exchange(8'hC3, 8'h5E, 8'h06, "R3 mode0");
        t_sticky();
        exchange(8'h01, 8'h80, 8'h06, "R3 mode0 second pattern");
        t_mode1();
        t_conflict();
        t_follower_ignores_own();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule